// File: doc/BRIEF.md
# Two-Level DMA Stream Arbiter

This block decides which of eight DMA streams may use a single shared bus port. Each stream raises a request bit and carries a priority level that software programs. The arbiter gives the port to the requesting stream with the highest level. When several requesting streams share that level, the lowest stream index wins, so stream 0 beats stream 1, stream 1 beats stream 2, and so on.

The winner comes out as a registered one-hot grant vector, a binary index and a valid bit. A grant holds until the owning stream finishes its current beat and pulses `done_i` for one cycle. Arbitration then runs again on the requests and levels present in that cycle, and the new grant appears one clock later. A newer, stronger request never preempts a grant that is in progress. When the arbiter is idle, it arbitrates every cycle.

Top module: `strm_arb`

## Requirements
- R1: After reset, `grant_o` is all zeros, `grant_idx_o` is 0 and `grant_vld_o` is low.
- R2: When no grant is active and no request bit is set, on the next clock `grant_o` is all zeros and `grant_vld_o` is low.
- R3: When a grant is issued, it goes to a requesting stream whose 2-bit level is the largest among all requesting streams. Level 3 is the highest and level 0 the lowest. Stream i's level occupies bits [2i+1:2i] of `prio_i`.
- R4: Among requesting streams that share the highest level, the stream with the smallest index receives the grant.
- R5: While `grant_vld_o` is high and `done_i` is low, the grant outputs stay unchanged, whatever happens to the requests and levels.
- R6: When `done_i` is high during an active grant, the next clock applies R2–R4 to the requests and levels of that cycle. The stream that just finished may win again.
- R7: `grant_o` has at most one bit set. `grant_vld_o` is high exactly when a bit is set, and then `grant_idx_o` is the position of that bit.
- R8: A `done_i` pulse while no grant is active has no effect beyond normal idle arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Per-stream request bits |
| prio_i | input | 16 | Per-stream 2-bit software level, stream i at [2i+1:2i] |
| done_i | input | 1 | One-cycle pulse: granted stream finished its beat |
| grant_o | output | 8 | One-hot grant, registered |
| grant_idx_o | output | 3 | Index of granted stream |
| grant_vld_o | output | 1 | A grant is active |

## Verification
The assertions assume that `done_i` is a pulse belonging to the current grant. They place no assumptions on requests or levels, which may change in any cycle, including in the middle of a grant. The stimulus includes `done_i` pulses that arrive while the arbiter is idle, to exercise R8. Randomly drawn levels often collide, which exercises the index tie-break. Directed cases cover an empty request vector, all streams at the same level, and a stronger request arriving during a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned STRM_NUM_DEF = 8;
    localparam int unsigned LVL_W_DEF    = 2;
endpackage

// File: rtl/arb_lvl_max.sv
module arb_lvl_max #(
    parameter int unsigned STRM_NUM = 8,
    parameter int unsigned LVL_W    = 2
) (
    input  logic [STRM_NUM-1:0]       req_i,
    input  logic [STRM_NUM*LVL_W-1:0] prio_i,
    output logic [LVL_W-1:0]          max_o,
    output logic                      any_o
);
    logic [LVL_W-1:0] lvl_eff [STRM_NUM];

    for (genvar g = 0; g < STRM_NUM; g++) begin : g_mask
        assign lvl_eff[g] = req_i[g] ? prio_i[g*LVL_W +: LVL_W] : '0;
    end

    always_comb begin
        max_o = '0;
        for (int i = 0; i < STRM_NUM; i++) begin
            if (lvl_eff[i] > max_o) begin
                max_o = lvl_eff[i];
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int unsigned STRM_NUM = 8,
    parameter int unsigned LVL_W    = 2,
    localparam int unsigned IDX_W   = $clog2(STRM_NUM)
) (
    input  logic [STRM_NUM-1:0]       req_i,
    input  logic [STRM_NUM*LVL_W-1:0] prio_i,
    input  logic [LVL_W-1:0]          max_i,
    output logic [STRM_NUM-1:0]       onehot_o,
    output logic [IDX_W-1:0]          idx_o
);
    logic [STRM_NUM-1:0] cand;

    for (genvar g = 0; g < STRM_NUM; g++) begin : g_cand
        assign cand[g] = req_i[g] && (prio_i[g*LVL_W +: LVL_W] == max_i);
    end

    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = STRM_NUM - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        if (|cand) begin
            onehot_o[idx_o] = 1'b1;
        end
    end
endmodule

// File: rtl/strm_arb.sv
module strm_arb #(
    parameter int unsigned STRM_NUM = arb_pkg::STRM_NUM_DEF,
    parameter int unsigned LVL_W    = arb_pkg::LVL_W_DEF,
    localparam int unsigned IDX_W   = $clog2(STRM_NUM)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [STRM_NUM-1:0]       req_i,
    input  logic [STRM_NUM*LVL_W-1:0] prio_i,
    input  logic                      done_i,
    output logic [STRM_NUM-1:0]       grant_o,
    output logic [IDX_W-1:0]          grant_idx_o,
    output logic                      grant_vld_o
);
    typedef struct packed {
        logic [STRM_NUM-1:0] grant;
        logic [IDX_W-1:0]    idx;
        logic                vld;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [LVL_W-1:0]    lvl_max;
    logic                req_any;
    logic [STRM_NUM-1:0] win_oh;
    logic [IDX_W-1:0]    win_idx;

    arb_lvl_max #(.STRM_NUM(STRM_NUM), .LVL_W(LVL_W)) u_lvl_max (
        .req_i  (req_i),
        .prio_i (prio_i),
        .max_o  (lvl_max),
        .any_o  (req_any)
    );

    arb_pick #(.STRM_NUM(STRM_NUM), .LVL_W(LVL_W)) u_pick (
        .req_i    (req_i),
        .prio_i   (prio_i),
        .max_i    (lvl_max),
        .onehot_o (win_oh),
        .idx_o    (win_idx)
    );

    // Re-arbitrate only when idle or when the holder signals completion.
    always_comb begin
        st_d = st_q;
        if (!st_q.vld || done_i) begin
            st_d.grant = win_oh;
            st_d.idx   = req_any ? win_idx : '0;
            st_d.vld   = req_any;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o     = st_q.grant;
    assign grant_idx_o = st_q.idx;
    assign grant_vld_o = st_q.vld;

    // R7: grant shape
    p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o) && (grant_vld_o == (grant_o != '0)));
    p_idx_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_vld_o |-> grant_o[grant_idx_o]);

    // R5: no preemption mid-beat
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_vld_o && !done_i) |=> ($stable(grant_o) && $stable(grant_idx_o) && grant_vld_o));

    // R2: no requests while arbitrating leaves the port idle
    p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!grant_vld_o || done_i) && (req_i == '0)) |=> !grant_vld_o);

    // R6: a fresh grant always belongs to a stream that was requesting
    p_from_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!grant_vld_o || done_i) |=> (!grant_vld_o || (($past(req_i) & grant_o) != '0)));

    // R3: the chosen stream's level is not below any requester's level
    p_lvl_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_any && (!grant_vld_o || done_i)) |-> (prio_i[win_idx*LVL_W +: LVL_W] == lvl_max && req_i[win_idx]));
endmodule

// File: tb/strm_arb_bench.sv
module strm_arb_bench;
    localparam int N = 8;
    localparam int W = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*W-1:0] prio = '0;
    logic          done = 1'b0;
    logic [N-1:0]  grant;
    logic [2:0]    gidx;
    logic          gvld;

    int checks = 0;
    int errors = 0;

    // Model state
    logic          m_vld = 1'b0;
    int            m_idx = 0;

    always #5 clk = ~clk;

    strm_arb u_strm_arb (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio), .done_i(done),
        .grant_o(grant), .grant_idx_o(gidx), .grant_vld_o(gvld)
    );

    function automatic int pick(input logic [N-1:0] r, input logic [N*W-1:0] p);
        int best = -1;
        int bl = -1;
        for (int i = 0; i < N; i++) begin
            if (r[i] && int'(p[i*W +: W]) > bl) begin
                bl = int'(p[i*W +: W]);
                best = i;
            end
        end
        return best;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [N-1:0] eg;
        eg = m_vld ? (N'(1) << m_idx) : '0;
        chk({tag, " R7 vld"}, int'(gvld), int'(m_vld));
        chk({tag, " grant"}, int'(grant), int'(eg));
        chk({tag, " idx"}, int'(gidx), m_vld ? m_idx : 0);
    endtask

    // Drive at negedge, update model, check at following negedge.
    task automatic step(input logic [N-1:0] r, input logic [N*W-1:0] p, input logic d, input string tag);
        int w;
        req = r; prio = p; done = d;
        if (!m_vld || d) begin
            w = pick(r, p);
            m_vld = (w >= 0);
            m_idx = (w >= 0) ? w : 0;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [N*W-1:0] all_lvl(input logic [W-1:0] l);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = l;
        return v;
    endfunction

    initial begin
        int seed;
        logic [N*W-1:0] pv;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        step('0, all_lvl(2'd3), 1'b0, "R2 no req");
        step('0, all_lvl(2'd0), 1'b1, "R8 done idle no req");
        // R4: all equal level, lowest index wins
        step(8'b1011_0100, all_lvl(2'd1), 1'b0, "R4 tie");
        chk("R4 tie index", int'(gidx), 2);
        // R5: stronger request arrives mid-grant
        pv = all_lvl(2'd0); pv[7*W +: W] = 2'd3;
        step(8'b1111_1111, pv, 1'b0, "R5 hold");
        chk("R5 held index", int'(gidx), 2);
        // R6 + R3: release, stream 7 highest
        step(8'b1111_1111, pv, 1'b1, "R6 rearb");
        chk("R3 highest level index", int'(gidx), 7);
        // R6: same stream may win again
        step(8'b1000_0001, pv, 1'b1, "R6 regrant");
        chk("R6 regrant index", int'(gidx), 7);
        // R2 via release with no requests
        step('0, pv, 1'b1, "R2 release empty");
        // R3: higher level beats lower index
        pv = all_lvl(2'd1); pv[5*W +: W] = 2'd2; pv[6*W +: W] = 2'd2;
        step(8'b0110_0011, pv, 1'b0, "R3 level over index");
        chk("R3 level over index value", int'(gidx), 5);
        // R5: requests drop during grant, grant held
        step('0, '0, 1'b0, "R5 req dropped");
        step('0, '0, 1'b1, "R6 release");

        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] r;
            logic [N*W-1:0] p;
            logic d;
            r = N'($urandom);
            if (($urandom % 6) == 0) r = '0;
            p = (N*W)'($urandom);
            d = (($urandom % 3) == 0);
            step(r, p, d, "R3 R4 R5 R6 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule